// File: doc/BRIEF.md
# Calendar Shadow Register Read Coherency

This block sits between a slow-clock calendar and a fast bus. It keeps bus-domain copies (shadows) of three calendar words: sub-second, time and date. The slow clock is brought into the bus domain through a synchronizer chain. On each rising slow edge the block copies the live calendar words into the shadows and raises a "synced" flag. Software clears this flag with a one-cycle pulse and waits for it to rise again.

Software may read the three words one at a time, so the block keeps such a sequence coherent. Reading the sub-second word freezes the time and date shadows. Reading the time word freezes the date shadow. Either freeze lasts until the date word is read. In bypass mode the outputs follow the live calendar words directly and no copying takes place.

The bus clock must run at seven or more times the slow clock, and never slower than it. Under that condition the live words have been stable for several bus cycles when the copy is taken. All inputs and outputs are plain level or strobe signals. Data is not streamed, so there is no valid/ready back-pressure.

Top module: `cal_shadow_coherency`

## Requirements
- R1: After reset the shadows hold their parameter defaults (sub-second 0, time 0, date 24'h000101), the synced flag is 0 and no freeze is held.
- R2: With bypass off, a rising edge on the slow clock updates the shadows at the third bus clock edge after the slow edge first appears. The rising edge passes through a two-flop synchronizer and one edge-detect flop. The sub-second shadow is updated on every such refresh.
- R3: A refresh that updates all three shadows sets the synced flag.
- R4: A one-cycle clear pulse drives the synced flag to 0, and the flag stays 0 until the next refresh that updates all three shadows.
- R5: With bypass off, a sub-second read freezes the time and date shadows against later refreshes. While any shadow is frozen, a refresh does not set the synced flag.
- R6: With bypass off, a time read freezes only the date shadow. The sub-second and time shadows keep refreshing.
- R7: A date read releases any freeze it finds. The shadows keep their values until the next refresh, which updates all three. A date read while nothing is frozen has no effect on the shadows or on the flag.
- R8: With bypass on, the outputs equal the live calendar words. No shadow is refreshed, the flag is not set, and sub-second or time reads do not freeze anything.
- R9: When a clear pulse falls in the same cycle as a flag-setting refresh, the flag ends at 1.
- R10: A sub-second or time read in the same cycle as a refresh already freezes the higher-order shadows for that refresh.
- R11: A date read in the same cycle as a refresh leaves the frozen shadows unchanged for that refresh. The release takes effect for the next refresh.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rtc_clk_i | input | 1 | Slow calendar clock, sampled as data |
| bypass_i | input | 1 | 1: outputs follow the live words, no refresh |
| live_ss_i | input | 16 | Live sub-second counter |
| live_time_i | input | 24 | Live time word |
| live_date_i | input | 24 | Live date word |
| rd_ss_i | input | 1 | Sub-second read strobe |
| rd_time_i | input | 1 | Time read strobe |
| rd_date_i | input | 1 | Date read strobe |
| flag_clr_i | input | 1 | Synced-flag clear pulse |
| ss_o | output | 16 | Sub-second read value |
| time_o | output | 24 | Time read value |
| date_o | output | 24 | Date read value |
| synced_o | output | 1 | Synced flag |

## Verification
Two pairs of events can fall in the same bus cycle. A software clear of the synced flag can coincide with the refresh that would set it. A read strobe can coincide with the refresh itself. To provoke both, the bench raises the slow clock and then drives the strobe in the exact cycle where the edge-detect pulse is high. That cycle is the second bus edge after the slow edge. After the third edge the bench judges the flag (it must be 1) and judges which shadows took the new live words. A sub-second read must already block the time and date copies, and a date read must not yet let them through.

// File: rtl/cal_shadow_pkg.sv
package cal_shadow_pkg;
  localparam int unsigned SS_W_DEF   = 16;
  localparam int unsigned TIME_W_DEF = 24;
  localparam int unsigned DATE_W_DEF = 24;
  localparam int unsigned SYNC_STAGES_DEF = 2;

  // freeze levels applied to a refresh
  typedef struct packed {
    logic time_frz;
    logic date_frz;
  } frz_t;
endpackage

// File: rtl/cal_edge_sync.sv
module cal_edge_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic async_i,
  output logic rise_o
);
  localparam int unsigned LAST = STAGES;

  logic [LAST:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q[0] <= 1'b0;
    else        chain_q[0] <= async_i;
  end

  for (genvar g = 1; g <= LAST; g++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain_q[g] <= 1'b0;
      else        chain_q[g] <= chain_q[g-1];
    end
  end

  assign rise_o = chain_q[LAST-1] & ~chain_q[LAST];

  initial assert (STAGES >= 2) else $error("synchronizer needs two flops");

  // R2: edge detect emits isolated one-cycle pulses
  p_single_pulse_r2: assert property (@(posedge clk) disable iff (!rst_n)
    rise_o |=> !rise_o);
endmodule

// File: rtl/cal_lock_ctrl.sv
module cal_lock_ctrl
  import cal_shadow_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic bypass_i,
  input  logic rd_ss_i,
  input  logic rd_time_i,
  input  logic rd_date_i,
  output frz_t frz_o
);
  logic ss_rd_eff, time_rd_eff;
  logic hold_time_q, hold_date_q;
  logic hold_time_d, hold_date_d;

  assign ss_rd_eff   = rd_ss_i & ~bypass_i;
  assign time_rd_eff = rd_time_i & ~bypass_i;

  always_comb begin
    hold_time_d = hold_time_q;
    hold_date_d = hold_date_q;
    if (rd_date_i) begin
      hold_time_d = 1'b0;
      hold_date_d = 1'b0;
    end
    if (ss_rd_eff)                hold_time_d = 1'b1;
    if (ss_rd_eff || time_rd_eff) hold_date_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_time_q <= 1'b0;
      hold_date_q <= 1'b0;
    end else begin
      hold_time_q <= hold_time_d;
      hold_date_q <= hold_date_d;
    end
  end

  // a read in the refresh cycle already counts (R10)
  assign frz_o.time_frz = hold_time_q | ss_rd_eff;
  assign frz_o.date_frz = hold_date_q | ss_rd_eff | time_rd_eff;

  // R5: a held freeze persists until a date read
  p_hold_persist_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (hold_date_q && !rd_date_i) |=> hold_date_q);
  // R6: a time read outside bypass freezes the date shadow
  p_time_locks_date_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_time_i && !bypass_i) |=> hold_date_q);
  // R7: a lone date read leaves nothing held
  p_date_release_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_date_i && !rd_ss_i && !rd_time_i) |=> (!hold_date_q && !hold_time_q));
  // R8: reads in bypass never create a freeze
  p_bypass_nolock_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (bypass_i && !hold_date_q) |=> !hold_date_q);
endmodule

// File: rtl/cal_shadow_reg.sv
module cal_shadow_reg #(
  parameter int unsigned    W   = 16,
  parameter logic [W-1:0]   RST = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load_i,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      q_o <= RST;
    else if (load_i) q_o <= d_i;
  end
endmodule

// File: rtl/cal_sync_flag.sv
module cal_sync_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic clr_i,
  output logic flag_o
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     flag_o <= 1'b0;
    else if (set_i) flag_o <= 1'b1;
    else if (clr_i) flag_o <= 1'b0;
  end

  // R9: set beats clear in the same cycle
  p_set_wins_r9: assert property (@(posedge clk) disable iff (!rst_n)
    set_i |=> flag_o);
  // R4: a clear without a set drops the flag
  p_clear_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_i && !set_i) |=> !flag_o);
endmodule

// File: rtl/cal_shadow_coherency.sv
module cal_shadow_coherency
  import cal_shadow_pkg::*;
#(
  parameter int unsigned SS_W        = SS_W_DEF,
  parameter int unsigned TIME_W      = TIME_W_DEF,
  parameter int unsigned DATE_W      = DATE_W_DEF,
  parameter int unsigned SYNC_STAGES = SYNC_STAGES_DEF,
  parameter logic [SS_W-1:0]   SS_RST   = '0,
  parameter logic [TIME_W-1:0] TIME_RST = '0,
  parameter logic [DATE_W-1:0] DATE_RST = DATE_W'(24'h000101)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rtc_clk_i,
  input  logic              bypass_i,
  input  logic [SS_W-1:0]   live_ss_i,
  input  logic [TIME_W-1:0] live_time_i,
  input  logic [DATE_W-1:0] live_date_i,
  input  logic              rd_ss_i,
  input  logic              rd_time_i,
  input  logic              rd_date_i,
  input  logic              flag_clr_i,
  output logic [SS_W-1:0]   ss_o,
  output logic [TIME_W-1:0] time_o,
  output logic [DATE_W-1:0] date_o,
  output logic              synced_o
);
  logic rise;
  frz_t frz;
  logic ld_ss, ld_time, ld_date, flag_set;
  logic [SS_W-1:0]   ss_sh;
  logic [TIME_W-1:0] time_sh;
  logic [DATE_W-1:0] date_sh;

  cal_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .async_i(rtc_clk_i), .rise_o(rise));

  cal_lock_ctrl u_lock (
    .clk(clk), .rst_n(rst_n), .bypass_i(bypass_i),
    .rd_ss_i(rd_ss_i), .rd_time_i(rd_time_i), .rd_date_i(rd_date_i),
    .frz_o(frz));

  assign ld_ss    = rise & ~bypass_i;
  assign ld_time  = ld_ss & ~frz.time_frz;
  assign ld_date  = ld_ss & ~frz.date_frz;
  assign flag_set = ld_ss & ~frz.time_frz & ~frz.date_frz;

  cal_shadow_reg #(.W(SS_W), .RST(SS_RST)) u_ss (
    .clk(clk), .rst_n(rst_n), .load_i(ld_ss), .d_i(live_ss_i), .q_o(ss_sh));
  cal_shadow_reg #(.W(TIME_W), .RST(TIME_RST)) u_time (
    .clk(clk), .rst_n(rst_n), .load_i(ld_time), .d_i(live_time_i), .q_o(time_sh));
  cal_shadow_reg #(.W(DATE_W), .RST(DATE_RST)) u_date (
    .clk(clk), .rst_n(rst_n), .load_i(ld_date), .d_i(live_date_i), .q_o(date_sh));

  cal_sync_flag u_flag (
    .clk(clk), .rst_n(rst_n), .set_i(flag_set), .clr_i(flag_clr_i), .flag_o(synced_o));

  assign ss_o   = bypass_i ? live_ss_i   : ss_sh;
  assign time_o = bypass_i ? live_time_i : time_sh;
  assign date_o = bypass_i ? live_date_i : date_sh;

  // R5: a frozen time shadow does not move
  p_frozen_time_r5: assert property (@(posedge clk) disable iff (!rst_n)
    frz.time_frz |=> $stable(time_sh));
  // R6: a frozen date shadow does not move
  p_frozen_date_r6: assert property (@(posedge clk) disable iff (!rst_n)
    frz.date_frz |=> $stable(date_sh));
  // R8: no refresh of any shadow in bypass
  p_bypass_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    bypass_i |=> ($stable(ss_sh) && $stable(time_sh) && $stable(date_sh)));
  // R3: the flag only rises after a synchronized slow edge
  p_flag_cause_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(synced_o) |-> $past(rise));
endmodule

// File: tb/sim_cal_shadow_coherency.sv
module sim_cal_shadow_coherency;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic rtc = 1'b0, byp = 1'b0, rss = 1'b0, rtm = 1'b0, rdt = 1'b0, clr = 1'b0;
  logic [15:0] lss = '0;
  logic [23:0] ltm = '0, ldt = '0;
  logic [15:0] ss;
  logic [23:0] tm, dt;
  logic syn;
  int checks = 0, errors = 0;
  bit  done = 0;

  always #4 clk = ~clk;

  cal_shadow_coherency u0 (
    .clk(clk), .rst_n(rst_n), .rtc_clk_i(rtc), .bypass_i(byp),
    .live_ss_i(lss), .live_time_i(ltm), .live_date_i(ldt),
    .rd_ss_i(rss), .rd_time_i(rtm), .rd_date_i(rdt), .flag_clr_i(clr),
    .ss_o(ss), .time_o(tm), .date_o(dt), .synced_o(syn));

  task automatic chk(string req, logic [23:0] act, logic [23:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic chk3(string req, logic [15:0] s, logic [23:0] t, logic [23:0] d);
    chk(req, {8'h0, ss}, {8'h0, s});
    chk(req, tm, t);
    chk(req, dt, d);
  endtask

  // one slow period; strobes s/t/d/c are driven in the refresh cycle
  task automatic tick(logic [15:0] s, logic [23:0] t, logic [23:0] d,
                      logic ps = 0, logic pt = 0, logic pd = 0, logic pc = 0);
    @(negedge clk);
    rtc = 1'b1; lss = s; ltm = t; ldt = d;
    @(posedge clk); @(posedge clk);
    @(negedge clk);
    rss = ps; rtm = pt; rdt = pd; clr = pc;
    @(posedge clk);
    @(negedge clk);
    rss = 0; rtm = 0; rdt = 0; clr = 0;
    rtc = 1'b0;
    repeat (4) @(negedge clk);
  endtask

  task automatic pulse(ref logic sig);
    @(negedge clk); sig = 1'b1;
    @(negedge clk); sig = 1'b0;
  endtask

  task automatic t_reset();
    chk3("R1", 16'h0, 24'h0, 24'h000101);
    chk("R1", {23'h0, syn}, 24'h0);
  endtask

  task automatic t_refresh();
    tick(16'h001a, 24'h123456, 24'h250314);
    chk3("R2", 16'h001a, 24'h123456, 24'h250314);
    chk("R3", {23'h0, syn}, 24'h1);
  endtask

  task automatic t_clear();
    pulse(clr);
    chk("R4", {23'h0, syn}, 24'h0);
    repeat (8) @(negedge clk);
    chk("R4", {23'h0, syn}, 24'h0);
    tick(16'h0020, 24'h123457, 24'h250314);
    chk("R4", {23'h0, syn}, 24'h1);
  endtask

  task automatic t_lock_ss();
    pulse(clr);
    pulse(rss);
    tick(16'h0030, 24'h130000, 24'h250315);
    chk3("R5", 16'h0030, 24'h123457, 24'h250314);
    chk("R5", {23'h0, syn}, 24'h0);
    pulse(rdt);
    chk3("R7", 16'h0030, 24'h123457, 24'h250314);
    tick(16'h0031, 24'h130001, 24'h250316);
    chk3("R7", 16'h0031, 24'h130001, 24'h250316);
    chk("R7", {23'h0, syn}, 24'h1);
  endtask

  task automatic t_lock_time();
    pulse(clr);
    pulse(rtm);
    tick(16'h0040, 24'h140000, 24'h250317);
    chk3("R6", 16'h0040, 24'h140000, 24'h250316);
    chk("R6", {23'h0, syn}, 24'h0);
    pulse(rdt);
    tick(16'h0041, 24'h140001, 24'h250318);
    chk3("R6", 16'h0041, 24'h140001, 24'h250318);
  endtask

  task automatic t_date_alone();
    pulse(clr);
    pulse(rdt);
    chk("R7", {23'h0, syn}, 24'h0);
    tick(16'h0050, 24'h150000, 24'h250319);
    chk3("R7", 16'h0050, 24'h150000, 24'h250319);
    chk("R7", {23'h0, syn}, 24'h1);
  endtask

  task automatic t_bypass();
    pulse(clr);
    @(negedge clk); byp = 1'b1;
    lss = 16'h0055; ltm = 24'h155555; ldt = 24'h250320;
    #1 chk3("R8", 16'h0055, 24'h155555, 24'h250320);
    pulse(rss);
    tick(16'h0060, 24'h160000, 24'h250321);
    chk3("R8", 16'h0060, 24'h160000, 24'h250321);
    chk("R8", {23'h0, syn}, 24'h0);
    @(negedge clk); byp = 1'b0;
    #1 chk3("R8", 16'h0050, 24'h150000, 24'h250319);
    tick(16'h0061, 24'h160001, 24'h250322);
    chk3("R8", 16'h0061, 24'h160001, 24'h250322);
  endtask

  task automatic t_clr_vs_set();
    pulse(clr);
    tick(16'h0070, 24'h170000, 24'h250323, 0, 0, 0, 1);
    chk("R9", {23'h0, syn}, 24'h1);
  endtask

  task automatic t_read_in_refresh();
    pulse(clr);
    tick(16'h0080, 24'h180000, 24'h250324, 1, 0, 0, 0);
    chk3("R10", 16'h0080, 24'h170000, 24'h250323);
    chk("R10", {23'h0, syn}, 24'h0);
  endtask

  task automatic t_date_in_refresh();
    tick(16'h0090, 24'h190000, 24'h250325, 0, 0, 1, 0);
    chk3("R11", 16'h0090, 24'h170000, 24'h250323);
    chk("R11", {23'h0, syn}, 24'h0);
    tick(16'h0091, 24'h190001, 24'h250326);
    chk3("R11", 16'h0091, 24'h190001, 24'h250326);
    chk("R11", {23'h0, syn}, 24'h1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_refresh();
    t_clear();
    t_lock_ss();
    t_lock_time();
    t_date_alone();
    t_bypass();
    t_clr_vs_set();
    t_read_in_refresh();
    t_date_in_refresh();
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule